// File: doc/BRIEF.md
# SD card clock divider

This block derives the card-side clock of an SD/MMC host from the controller's base clock. It has two counter stages. The first is a power-of-two prescaler that counts base cycles. The second is a linear divider that counts prescaler wraps. The total division is the product of the two stages. A double-data-rate flag changes how the prescaler field is read, so that the same encoded value selects twice the prescale. The divided clock is a register output that changes only on base clock edges. It has close to 50% duty. A one-cycle tick marks each of its rising edges, so logic in the base domain can act on card clock edges without a second clock.

An enable input gates the card clock. When the enable is removed, the current high phase runs to its full width and the output then stays low, so no runt pulse is cut off. When the enable returns, a full period starts at once. A stability flag stays low while the clock is stopped or a new setting is pending. It rises only after one whole period has run at the setting now applied. Software uses it to know when a new card frequency is in force. Computing field values from a target frequency (for example 400 kHz for card identification, or at most 52 MHz and never above the base clock) is left to software.

Top module: `sdcard_clk_divider`

## Requirements
- R1: While and after reset, with the enable low, `card_clk`, `card_tick` and `clk_stable` are 0.
- R2: With `ddr_mode` = 0, a `pre_field` of 0 selects prescale 1 (bypass). A nonzero field selects prescale 2^(h+1), where h is the index of its highest set bit; lower set bits are ignored.
- R3: With `ddr_mode` = 1, a `pre_field` of 0 selects prescale 2. A nonzero field selects 2^(h+2), capped at 256.
- R4: `div_field` value d selects divisor d+1, and one card clock period lasts prescale × divisor base cycles. A product of 1 is raised to 2.
- R5: Each period of N base cycles starts with `card_clk` high for floor(N/2) cycles and then low for the remaining cycles.
- R6: `card_tick` is high for exactly the cycles in which `card_clk` has just risen, and at no other time.
- R7: While `clk_en` is low, `card_clk` stays low. When the enable drops during a high phase, that phase completes at full width and no further pulse follows. When the enable rises again, a new period starts at the next edge.
- R8: A setting change while the clock runs does not alter the current period. It takes effect from the next period boundary.
- R9: `clk_stable` is 0 while the clock is stopped and in the first period after a start. It rises together with the tick of the second period.
- R10: One cycle after the decoded setting differs from the one in use, `clk_stable` is 0. It rises again together with the tick that ends the first full period at the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_field | input | 8 | Encoded power-of-two prescale (highest set bit used) |
| div_field | input | 4 | Divisor minus one |
| ddr_mode | input | 1 | Double-data-rate reading of the prescale field |
| clk_en | input | 1 | Card clock enable |
| card_clk | output | 1 | Divided card clock |
| card_tick | output | 1 | One-cycle pulse on each card clock rise |
| clk_stable | output | 1 | Card clock has run a full period at the current setting |

## Verification
The hardest case to reach from the ports is a setting change that lands in the middle of a running period, after the stability flag has already risen. The old period must finish unchanged, the flag must drop at once, and it must return only one full new period later. The stimulus counts base cycles from the launch edge and rewrites the fields a few cycles into the second period. It also drops the enable a few cycles into a long high phase, to show that the pulse is not cut short. A scoreboard compares every pulse, low gap and flag value against a queue of expected periods.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int SDC_PRE_W    = 8;
    localparam int SDC_DIV_W    = 4;
    localparam int SDC_PLOG_MAX = SDC_PRE_W;
    localparam int SDC_PLOG_W   = $clog2(SDC_PLOG_MAX + 2);
    localparam int SDC_CNT_W    = SDC_PLOG_MAX;
    localparam int SDC_POS_W    = SDC_PLOG_MAX + SDC_DIV_W;
    localparam int SDC_N_W      = SDC_POS_W + 1;

    localparam logic [SDC_PLOG_W-1:0] SDC_PLOG_CAP = SDC_PLOG_W'(SDC_PLOG_MAX);

    // decoded divider setting: log2 of prescale and divisor minus one
    typedef struct packed {
        logic [SDC_PLOG_W-1:0] plog;
        logic [SDC_DIV_W-1:0]  dm1;
    } sdc_cfg_t;

    // number of base cycles the card clock is high in one period
    function automatic logic [SDC_N_W-1:0] sdc_half(input sdc_cfg_t c);
        logic [SDC_N_W-1:0] n;
        n = (SDC_N_W'(c.dm1) + SDC_N_W'(1)) << c.plog;
        return n >> 1;
    endfunction

    // terminal value of the prescale counter
    function automatic logic [SDC_CNT_W-1:0] sdc_pmask(input logic [SDC_PLOG_W-1:0] plog);
        logic [SDC_N_W-1:0] t;
        t = (SDC_N_W'(1) << plog) - SDC_N_W'(1);
        return t[SDC_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sdc_setting_decode.sv
module sdc_setting_decode
    import sdc_pkg::*;
(
    input  logic [SDC_PRE_W-1:0] pre_field,
    input  logic [SDC_DIV_W-1:0] div_field,
    input  logic                 ddr_mode,
    output sdc_cfg_t             cfg
);

    logic                  any_set;
    logic [SDC_PLOG_W-1:0] top_bit;
    logic [SDC_PLOG_W-1:0] raw_log;

    // priority encode: the highest set bit wins (R2)
    always_comb begin
        any_set = 1'b0;
        top_bit = '0;
        for (int i = 0; i < SDC_PRE_W; i++) begin
            if (pre_field[i]) begin
                any_set = 1'b1;
                top_bit = SDC_PLOG_W'(i);
            end
        end
    end

    always_comb begin
        if (any_set)
            raw_log = top_bit + (ddr_mode ? SDC_PLOG_W'(2) : SDC_PLOG_W'(1));
        else
            raw_log = ddr_mode ? SDC_PLOG_W'(1) : '0;
        cfg.plog = (raw_log > SDC_PLOG_CAP) ? SDC_PLOG_CAP : raw_log;
        // a total division of one cannot be built from base edges: use two (R4)
        if (cfg.plog == '0 && div_field == '0)
            cfg.dm1 = SDC_DIV_W'(1);
        else
            cfg.dm1 = div_field;
        p_plog_cap_r3: assert (cfg.plog <= SDC_PLOG_CAP);
    end

endmodule

// File: rtl/sdc_cascade_div.sv
module sdc_cascade_div
    import sdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_en,
    input  sdc_cfg_t cfg_in,
    output sdc_cfg_t cfg_q,
    output logic     run_q,
    output logic     at_end,
    output logic     launch,
    output logic     stop,
    output logic     card_clk_q,
    output logic     card_tick_q
);

    logic [SDC_CNT_W-1:0] p_cnt;
    logic [SDC_DIV_W-1:0] d_cnt;
    logic [SDC_CNT_W-1:0] p_term;
    logic                 p_last;
    logic                 d_last;
    logic [SDC_CNT_W-1:0] p_nx;
    logic [SDC_DIV_W-1:0] d_nx;
    logic [SDC_N_W-1:0]   pos_nx;
    logic                 high_nx;

    assign p_term = sdc_pmask(cfg_q.plog);
    assign p_last = (p_cnt == p_term);
    assign d_last = (d_cnt == cfg_q.dm1);
    assign at_end = run_q && p_last && d_last;

    // stop only during a low phase so a high pulse is never shortened (R7)
    assign stop   = run_q && !clk_en && !card_clk_q;
    assign launch = !stop && ((!run_q && clk_en) || at_end);

    // cascade: the divider stage advances when the prescale stage wraps
    assign p_nx    = p_last ? '0 : p_cnt + SDC_CNT_W'(1);
    assign d_nx    = p_last ? d_cnt + SDC_DIV_W'(1) : d_cnt;
    assign pos_nx  = (SDC_N_W'(d_nx) << cfg_q.plog) | SDC_N_W'(p_nx);
    assign high_nx = (pos_nx < sdc_half(cfg_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            run_q       <= 1'b0;
            p_cnt       <= '0;
            d_cnt       <= '0;
            card_clk_q  <= 1'b0;
            card_tick_q <= 1'b0;
        end else if (stop) begin
            run_q       <= 1'b0;
            p_cnt       <= '0;
            d_cnt       <= '0;
            card_clk_q  <= 1'b0;
            card_tick_q <= 1'b0;
        end else if (launch) begin
            // new setting is applied only at a period boundary (R8)
            cfg_q       <= cfg_in;
            run_q       <= 1'b1;
            p_cnt       <= '0;
            d_cnt       <= '0;
            card_clk_q  <= 1'b1;
            card_tick_q <= 1'b1;
        end else if (run_q) begin
            p_cnt       <= p_nx;
            d_cnt       <= d_nx;
            card_clk_q  <= high_nx;
            card_tick_q <= 1'b0;
        end else begin
            card_clk_q  <= 1'b0;
            card_tick_q <= 1'b0;
        end
    end

    p_tick_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        card_tick_q |-> (card_clk_q && !$past(card_clk_q)));

    p_rise_ticks_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk_q) |-> card_tick_q);

    p_gate_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !card_clk_q) |=> !card_clk_q);

    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (d_cnt <= cfg_q.dm1 && p_cnt <= sdc_pmask(cfg_q.plog)));

endmodule

// File: rtl/sdc_stable_track.sv
module sdc_stable_track
    import sdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_q,
    input  logic     at_end,
    input  logic     launch,
    input  logic     stop,
    input  sdc_cfg_t cfg_in,
    input  sdc_cfg_t cfg_q,
    output logic     stable_q
);

    logic mismatch;
    logic clean_q;

    assign mismatch = (cfg_in != cfg_q);

    // clean_q: the running period has seen no setting other than the one applied
    always_ff @(posedge clk) begin
        if (rst) begin
            stable_q <= 1'b0;
            clean_q  <= 1'b0;
        end else if (launch) begin
            stable_q <= at_end && clean_q && !mismatch;
            clean_q  <= 1'b1;
        end else if (stop || !run_q || mismatch) begin
            stable_q <= 1'b0;
            clean_q  <= 1'b0;
        end
    end

    p_stable_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
        stable_q |-> run_q);

    p_stable_rise_at_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(stable_q) |-> $past(at_end));

    p_mismatch_drops_r10: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> !stable_q);

endmodule

// File: rtl/sdcard_clk_divider.sv
module sdcard_clk_divider
    import sdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SDC_PRE_W-1:0] pre_field,
    input  logic [SDC_DIV_W-1:0] div_field,
    input  logic                 ddr_mode,
    input  logic                 clk_en,
    output logic                 card_clk,
    output logic                 card_tick,
    output logic                 clk_stable
);

    sdc_cfg_t cfg_in;
    sdc_cfg_t cfg_q;
    logic     run_q;
    logic     at_end;
    logic     launch;
    logic     stop;

    sdc_setting_decode u_decode (
        .pre_field (pre_field),
        .div_field (div_field),
        .ddr_mode  (ddr_mode),
        .cfg       (cfg_in)
    );

    sdc_cascade_div u_div (
        .clk         (clk),
        .rst         (rst),
        .clk_en      (clk_en),
        .cfg_in      (cfg_in),
        .cfg_q       (cfg_q),
        .run_q       (run_q),
        .at_end      (at_end),
        .launch      (launch),
        .stop        (stop),
        .card_clk_q  (card_clk),
        .card_tick_q (card_tick)
    );

    sdc_stable_track u_stable (
        .clk      (clk),
        .rst      (rst),
        .run_q    (run_q),
        .at_end   (at_end),
        .launch   (launch),
        .stop     (stop),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q),
        .stable_q (clk_stable)
    );

endmodule

// File: tb/test_sdcard_clk_divider.sv
module test_sdcard_clk_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pre_field = '0;
    logic [3:0] div_field = '0;
    logic       ddr_mode = 1'b0;
    logic       clk_en = 1'b0;
    logic       card_clk;
    logic       card_tick;
    logic       clk_stable;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    hi;
        int    lo;
        bit    stab;
        string tag;
        string stag;
    } item_t;

    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcard_clk_divider i_sdcard_clk_divider (
        .clk        (clk),
        .rst        (rst),
        .pre_field  (pre_field),
        .div_field  (div_field),
        .ddr_mode   (ddr_mode),
        .clk_en     (clk_en),
        .card_clk   (card_clk),
        .card_tick  (card_tick),
        .clk_stable (clk_stable)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected prescale from R2/R3
    function automatic int exp_presc(input logic [7:0] pre, input bit ddr);
        int top = -1;
        int l;
        for (int i = 0; i < 8; i++) if (pre[i]) top = i;
        if (top < 0) return ddr ? 2 : 1;
        l = top + (ddr ? 2 : 1);
        if (l > 8) l = 8;
        return 1 << l;
    endfunction

    function automatic int exp_n(input logic [7:0] pre, input logic [3:0] dv, input bit ddr);
        int n = exp_presc(pre, ddr) * (int'(dv) + 1);
        return (n == 1) ? 2 : n;
    endfunction

    task automatic push_periods(input int n, input int k, input int first_stab_idx,
                                input bit last_dc, input string tag, input string stag);
        item_t it;
        for (int i = 0; i < k; i++) begin
            it.hi   = n / 2;
            it.lo   = (last_dc && i == k - 1) ? 0 : n - n / 2;
            it.stab = (i >= first_stab_idx);
            it.tag  = tag;
            it.stag = stag;
            q.push_back(it);
        end
    endtask

    // run k full periods from a stopped state, then stop in the last low phase
    task automatic do_run(input logic [7:0] pre, input logic [3:0] dv, input bit ddr,
                          input int k, input string tag);
        int n = exp_n(pre, dv, ddr);
        @(negedge clk);
        pre_field = pre;
        div_field = dv;
        ddr_mode  = ddr;
        push_periods(n, k, 1, 1'b1, tag, "R9");
        clk_en = 1'b1;
        repeat (k * n) @(negedge clk);
        clk_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor: scoreboard of pulse widths, gaps, ticks and stability
    item_t cur;
    bit    have_cur = 1'b0;
    bit    prev_clk = 1'b0;
    bit    in_low   = 1'b0;
    int    hcnt = 0;
    int    lcnt = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (card_tick && !(card_clk && !prev_clk))
                chk(1'b0, "R6", "tick without rising edge", 1, 0);
            if (card_clk && !prev_clk) begin
                if (have_cur && in_low && cur.lo != 0)
                    chk(lcnt == cur.lo, cur.tag, "low cycles", lcnt, cur.lo);
                chk(card_tick == 1'b1, "R6", "tick at rise", int'(card_tick), 1);
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected pulse", 1, 0);
                    have_cur = 1'b0;
                end else begin
                    cur = q.pop_front();
                    have_cur = 1'b1;
                    chk(clk_stable == cur.stab, cur.stag, "stable at tick",
                        int'(clk_stable), int'(cur.stab));
                end
                hcnt   = 1;
                in_low = 1'b0;
            end else if (card_clk) begin
                hcnt++;
            end else if (prev_clk) begin
                if (have_cur)
                    chk(hcnt == cur.hi, "R5", "high cycles", hcnt, cur.hi);
                lcnt   = 1;
                in_low = 1'b1;
            end else if (in_low) begin
                lcnt++;
            end
            prev_clk = card_clk;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int na;
        int nb;
        repeat (3) @(negedge clk);
        chk(card_clk == 1'b0 && card_tick == 1'b0 && clk_stable == 1'b0, "R1",
            "outputs in reset", int'({card_clk, card_tick, clk_stable}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(card_clk == 1'b0, "R1", "card_clk after reset", int'(card_clk), 0);
        chk(card_tick == 1'b0, "R1", "card_tick after reset", int'(card_tick), 0);
        chk(clk_stable == 1'b0, "R1", "clk_stable after reset", int'(clk_stable), 0);

        // fields move while disabled: nothing may toggle (R7)
        pre_field = 8'h03;
        div_field = 4'h2;
        repeat (30) @(negedge clk);
        chk(card_clk == 1'b0, "R7", "idle with enable low", int'(card_clk), 0);

        do_run(8'h00, 4'h0, 1'b0, 4, "R4");   // product 1 raised to 2
        do_run(8'h00, 4'h2, 1'b0, 3, "R2");   // bypass, odd total 3
        do_run(8'h01, 4'h4, 1'b0, 3, "R4");   // 2 x 5
        do_run(8'h06, 4'h0, 1'b0, 3, "R2");   // highest bit only: 8
        do_run(8'h00, 4'h2, 1'b1, 3, "R3");   // ddr zero field: 2 x 3
        do_run(8'h10, 4'h1, 1'b1, 2, "R3");   // ddr 64 x 2
        do_run(8'h80, 4'h0, 1'b1, 2, "R3");   // ddr cap at 256
        do_run(8'hFF, 4'h3, 1'b0, 2, "R2");   // 256 x 4
        do_run(8'h80, 4'hF, 1'b0, 2, "R4");   // largest: 4096
        chk(clk_stable == 1'b0, "R9", "stable after stop", int'(clk_stable), 0);

        // enable dropped early in a long high phase (R7)
        @(negedge clk);
        pre_field = 8'h01;
        div_field = 4'h7;
        ddr_mode  = 1'b0;
        push_periods(16, 1, 1, 1'b1, "R7", "R9");
        clk_en = 1'b1;
        repeat (3) @(negedge clk);
        clk_en = 1'b0;
        chk(card_clk == 1'b1, "R7", "still high after enable drop", int'(card_clk), 1);
        repeat (40) @(negedge clk);
        chk(card_clk == 1'b0, "R7", "held low after gating", int'(card_clk), 0);

        // setting change in the middle of the second period (R8, R10)
        na = exp_n(8'h01, 4'h2, 1'b0);   // 6
        nb = exp_n(8'h04, 4'h0, 1'b0);   // 8
        @(negedge clk);
        pre_field = 8'h01;
        div_field = 4'h2;
        push_periods(na, 2, 1, 1'b0, "R8", "R9");
        push_periods(nb, 3, 1, 1'b1, "R8", "R10");
        clk_en = 1'b1;
        repeat (na + 2) @(negedge clk);
        chk(clk_stable == 1'b1, "R9", "stable before change", int'(clk_stable), 1);
        pre_field = 8'h04;
        div_field = 4'h0;
        @(negedge clk);
        chk(clk_stable == 1'b0, "R10", "stable drops on change", int'(clk_stable), 0);
        repeat (2 * na - (na + 3) + 3 * nb) @(negedge clk);
        clk_en = 1'b0;
        repeat (6) @(negedge clk);

        chk(q.size() == 0, "R5", "all expected periods seen", q.size(), 0);
        chk(card_clk == 1'b0, "R7", "final idle", int'(card_clk), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule